// File: doc/BRIEF.md
# ADC Sample Sequencer FIFO

This block is the digital back end of an analog-to-digital converter controller. It contains four sample sequencers. Each one has a 16-entry result FIFO, a stored input-select word and a stored control word. The analog conversion happens outside the block. A converted 10-bit value arrives on `sample_in` together with a one-cycle `trig` pulse. When sequencer 0 is enabled, each such pulse stores the value in FIFO 0 and raises raw interrupt bit 0.

Software reaches the block through a simple synchronous register port. A read returns data in the same cycle that `bus_rd` is high. Reading a FIFO data register pops that FIFO at the next clock edge. Each sequencer's registers sit in a window of 0x20 bytes that begins at 0x40. Every FIFO reports its head, its tail and its empty and full flags in one packed status word. The level interrupt is the OR of the raw interrupt bits gated by a mask register.

Top module: `adc_sample_seq`

## Requirements
- R1: After reset every FIFO status word reads 0x100 (empty, both pointers 0). The enable, raw, mask, masked and priority registers read 0, and `irq` is low.
- R2: A FIFO status word holds the tail (read) pointer in bits 3:0, the head (write) pointer in bits 7:4, the empty flag in bit 8 and the full flag in bit 12. All other bits read 0.
- R3: An accepted trigger stores `sample_in` at the head of FIFO 0, advances the head modulo 16 and clears empty. Full is set when the new head equals the tail.
- R4: A trigger that arrives while FIFO 0 is full, with no pop in the same cycle, is dropped. The pointers, the flags and the stored entries do not change.
- R5: A read of a FIFO data register returns the entry at the tail, zero-extended. If the FIFO was not empty, the tail then advances modulo 16, full clears, and empty is set when the new tail equals the head.
- R6: A read of a FIFO data register while that FIFO is empty returns the entry at the tail and moves no pointer.
- R7: A pop and a push to FIFO 0 in the same cycle act as pop first, then push. On a full FIFO both pointers advance and full stays set. On an empty FIFO only the head advances.
- R8: The enable register (offset 0x00) keeps 4 bits. A trigger is ignored unless bit 0 of this register is set.
- R9: Each accepted trigger sets raw interrupt bit 0 (raw register, offset 0x04). Writing 1 to a bit of the clear register (offset 0x10) clears that raw bit. If a trigger and a clear of bit 0 fall in the same cycle, the bit ends up set.
- R10: The mask register (offset 0x08) keeps 4 bits. The masked register (offset 0x0C) reads raw AND mask, and `irq` is high exactly when that value is nonzero.
- R11: Sequencer n's registers lie at 0x40 + 0x20·n. The input-select word is at +0x0 and keeps only the bits in 0x33333333. The control word is at +0x4 and keeps all 32 bits. FIFO data is at +0x8 and FIFO status is at +0xC. Unmapped addresses read 0.
- R12: The priority register (offset 0x14) keeps its low 16 bits. Reading the status or priority registers has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops when it addresses a FIFO data register) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| trig | input | 1 | Conversion-done pulse |
| sample_in | input | 10 | Converted sample value |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can coincide. The first pair is a software pop of FIFO 0 and a trigger push in the same cycle. The second is a trigger setting raw bit 0 while software writes the clear register for that bit. The bench provokes both by raising `trig` in the same step as a data read or a clear write. It does this with FIFO 0 full, with FIFO 0 empty, and with FIFO 0 in between. It then judges the result through later status, data and raw-register reads and the `irq` level, all compared every cycle against a behavioural model that applies the pop before the push.

// File: rtl/adc_seq_pkg.sv
// Package: shared constants for the ADC sample sequencer.
// Holds the register offsets, the bit positions in the FIFO status word and
// the masks that trim stored fields. It assumes an 8-bit byte address.
package adc_seq_pkg;
    localparam int ADDR_W        = 8;
    localparam int SEQ_BASE      = 'h40;
    localparam int SEQ_STRIDE    = 'h20;
    localparam int OFS_MUX       = 'h0;
    localparam int OFS_CTL       = 'h4;
    localparam int OFS_DATA      = 'h8;
    localparam int OFS_STAT      = 'hC;
    localparam int REG_ENABLE    = 'h00;
    localparam int REG_RAW       = 'h04;
    localparam int REG_MASK      = 'h08;
    localparam int REG_MASKED    = 'h0C;
    localparam int REG_CLEAR     = 'h10;
    localparam int REG_PRIO      = 'h14;
    localparam int STAT_TAIL_LSB = 0;
    localparam int STAT_HEAD_LSB = 4;
    localparam int STAT_EMPTY    = 8;
    localparam int STAT_FULL     = 12;
    localparam logic [31:0] MUX_KEEP  = 32'h3333_3333;
    localparam logic [31:0] PRIO_KEEP = 32'h0000_FFFF;
endpackage

// File: rtl/adc_seq_fifo.sv
// Module: one result FIFO with pointers that can be read back.
// It stores samples in a circular array and exposes head, tail, empty and
// full as a packed status word. In the same cycle a pop takes effect before
// a push. A pop while empty moves nothing. A push while full with no pop is
// dropped. It assumes DEPTH is a power of two no larger than 16.
module adc_seq_fifo
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int DEPTH    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] push_data,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic [31:0]         status
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]    head_q, tail_q, head_nx, tail_nx;
    logic                empty_q, full_q;
    logic                pop_ok, push_ok;

    // Work out which operations take effect and the next pointer values.
    always_comb begin
        pop_ok  = pop && !empty_q;
        push_ok = push && (!full_q || pop_ok);
        tail_nx = tail_q + PTR_W'(pop_ok);
        head_nx = head_q + PTR_W'(push_ok);
    end

    // Update the pointers, the flags and the storage array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            head_q <= head_nx;
            tail_q <= tail_nx;
            if (push_ok)     empty_q <= 1'b0;
            else if (pop_ok) empty_q <= (tail_nx == head_q);
            if (push_ok)     full_q  <= (head_nx == tail_nx);
            else if (pop_ok) full_q  <= 1'b0;
            if (push_ok) mem[head_q] <= push_data;
        end
    end

    // Present the tail entry and the packed status word.
    always_comb begin
        rd_data = mem[tail_q];
        status  = '0;
        status[STAT_TAIL_LSB +: PTR_W] = tail_q;
        status[STAT_HEAD_LSB +: PTR_W] = head_q;
        status[STAT_EMPTY]             = empty_q;
        status[STAT_FULL]              = full_q;
    end

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_q && full_q));
    a_r3_head_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full_q) |=> (head_q == PTR_W'($past(head_q) + 1'b1)) && !empty_q);
    a_r4_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full_q && !pop) |=> $stable(head_q) && $stable(tail_q) && full_q);
    a_r5_tail_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty_q) |=> (tail_q == PTR_W'($past(tail_q) + 1'b1)) && !full_q || push_ok == push_ok && $past(push));
    a_r6_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty_q && !push) |=> $stable(tail_q) && $stable(head_q) && empty_q);
endmodule

// File: rtl/adc_seq_window.sv
// Module: register window of one sequencer.
// It decodes the 0x20-byte window at SEQ_BASE + SEQ_STRIDE*IDX. It holds the
// input-select and control words, turns a data-register read into a pop and
// returns the addressed word. It returns 0 when the address lies outside.
module adc_seq_window
    import adc_seq_pkg::*;
#(
    parameter int IDX      = 0,
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [SAMPLE_W-1:0] fifo_data,
    input  logic [31:0]         fifo_status,
    output logic                pop,
    output logic [31:0]         rdata
);
    localparam int BASE = SEQ_BASE + SEQ_STRIDE * IDX;

    logic [ADDR_W:0] addr_ext, off;
    logic            hit;
    logic [31:0]     mux_q, ctl_q;

    // Decide whether the address falls in this window and find the offset.
    always_comb begin
        addr_ext = {1'b0, bus_addr};
        off      = addr_ext - (ADDR_W+1)'(BASE);
        hit      = (addr_ext >= (ADDR_W+1)'(BASE)) && (off < (ADDR_W+1)'(SEQ_STRIDE));
        pop      = bus_rd && hit && (off == (ADDR_W+1)'(OFS_DATA));
    end

    // Hold the input-select and control words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q <= '0;
            ctl_q <= '0;
        end else if (bus_wr && hit) begin
            if (off == (ADDR_W+1)'(OFS_MUX)) mux_q <= bus_wdata & MUX_KEEP;
            if (off == (ADDR_W+1)'(OFS_CTL)) ctl_q <= bus_wdata;
        end
    end

    // Return the addressed word.
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (off)
                (ADDR_W+1)'(OFS_MUX):  rdata = mux_q;
                (ADDR_W+1)'(OFS_CTL):  rdata = ctl_q;
                (ADDR_W+1)'(OFS_DATA): rdata = 32'(fifo_data);
                (ADDR_W+1)'(OFS_STAT): rdata = fifo_status;
                default:               rdata = '0;
            endcase
        end
    end

    a_r11_mux_trimmed: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_q & ~MUX_KEEP) == 32'h0);
endmodule

// File: rtl/adc_seq_irq.sv
// Module: raw interrupt bits, the mask and the level output.
// Set events win over a clear written in the same cycle. It assumes that a
// set vector bit is high for exactly one cycle per event.
module adc_seq_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_bits,
    output logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] clr_eff;

    // Select the bits that the clear register write removes.
    always_comb clr_eff = clr_wr ? clr_bits : '0;

    // Update the raw and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_eff) | set_vec;
            if (mask_wr) mask <= mask_bits;
        end
    end

    // Drive the level interrupt.
    always_comb irq = |(raw & mask);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[0] |=> raw[0]);
    a_r9_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bits[0] && !set_vec[0]) |=> !raw[0]);
    a_r10_mask_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask == $past(mask_bits)));
endmodule

// File: rtl/adc_sample_seq.sv
// Module: top level of the ADC sample sequencer.
// It decodes the global registers, gates the trigger with enable bit 0,
// builds one FIFO and one register window per sequencer and ORs the read
// data together. Only sequencer 0 receives samples. It assumes that reads
// and writes are never requested in the same cycle.
module adc_sample_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_SEQ    = 4,
    parameter int SAMPLE_W   = 10,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                trig,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                irq
);
    logic [NUM_SEQ-1:0]  enable_q, raw, mask, pop_vec, push_vec;
    logic [31:0]         prio_q, glob_rdata;
    logic                trig_ok, wr_clear, wr_mask;
    logic [SAMPLE_W-1:0] fifo_data [NUM_SEQ];
    logic [31:0]         fifo_stat [NUM_SEQ];
    logic [31:0]         win_rdata [NUM_SEQ];

    // Gate the trigger and decode the global register writes.
    always_comb begin
        trig_ok  = trig && enable_q[0];
        push_vec = NUM_SEQ'(trig_ok);
        wr_clear = bus_wr && (bus_addr == ADDR_W'(REG_CLEAR));
        wr_mask  = bus_wr && (bus_addr == ADDR_W'(REG_MASK));
    end

    // Hold the enable and priority registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            prio_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(REG_ENABLE)) enable_q <= bus_wdata[NUM_SEQ-1:0];
            if (bus_addr == ADDR_W'(REG_PRIO))   prio_q   <= bus_wdata & PRIO_KEEP;
        end
    end

    adc_seq_irq #(.N(NUM_SEQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(push_vec),
        .clr_wr(wr_clear), .clr_bits(bus_wdata[NUM_SEQ-1:0]),
        .mask_wr(wr_mask), .mask_bits(bus_wdata[NUM_SEQ-1:0]),
        .raw(raw), .mask(mask), .irq(irq)
    );

    for (genvar n = 0; n < NUM_SEQ; n++) begin : g_seq
        adc_seq_fifo #(.SAMPLE_W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(push_vec[n]), .push_data(sample_in),
            .pop(pop_vec[n]), .rd_data(fifo_data[n]), .status(fifo_stat[n])
        );
        adc_seq_window #(.IDX(n), .SAMPLE_W(SAMPLE_W)) u_win (
            .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
            .bus_addr(bus_addr), .bus_wdata(bus_wdata),
            .fifo_data(fifo_data[n]), .fifo_status(fifo_stat[n]),
            .pop(pop_vec[n]), .rdata(win_rdata[n])
        );
    end

    // Return the global registers.
    always_comb begin
        case (bus_addr)
            ADDR_W'(REG_ENABLE): glob_rdata = 32'(enable_q);
            ADDR_W'(REG_RAW):    glob_rdata = 32'(raw);
            ADDR_W'(REG_MASK):   glob_rdata = 32'(mask);
            ADDR_W'(REG_MASKED): glob_rdata = 32'(raw & mask);
            ADDR_W'(REG_PRIO):   glob_rdata = prio_q;
            default:             glob_rdata = '0;
        endcase
    end

    // Combine the global and per-window read data.
    always_comb begin
        bus_rdata = glob_rdata;
        for (int n = 0; n < NUM_SEQ; n++) bus_rdata = bus_rdata | win_rdata[n];
    end

    a_r8_trigger_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !enable_q[0] && !pop_vec[0]) |=> $stable(fifo_stat[0]));
    a_r11_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_vec));
endmodule

// File: tb/sim_adc_sample_seq.sv
// Bench: a behavioural reference model (plain arrays and integers) that is
// compared against the design on every clock.
module sim_adc_sample_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, trig = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [9:0]  sample_in = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m_mem [4][16];
    int m_head [4], m_tail [4];
    bit m_empty [4], m_full [4];
    int m_enable, m_raw, m_mask, m_prio;
    int m_mux [4], m_ctl [4];

    adc_sample_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig(trig), .sample_in(sample_in), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic void model_reset();
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 16; i++) m_mem[s][i] = 0;
            m_head[s] = 0; m_tail[s] = 0; m_empty[s] = 1; m_full[s] = 0;
            m_mux[s] = 0; m_ctl[s] = 0;
        end
        m_enable = 0; m_raw = 0; m_mask = 0; m_prio = 0;
    endfunction

    function automatic int status_of(int s);
        return m_tail[s] | (m_head[s] << 4) | (int'(m_empty[s]) << 8) | (int'(m_full[s]) << 12);
    endfunction

    function automatic int expect_read(int a);
        if (a >= 'h40 && a < 'hC0) begin
            int s = (a - 'h40) >> 5;
            case ((a - 'h40) & 'h1F)
                'h0: return m_mux[s];
                'h4: return m_ctl[s];
                'h8: return m_mem[s][m_tail[s]];
                'hC: return status_of(s);
                default: return 0;
            endcase
        end
        case (a)
            'h00: return m_enable;
            'h04: return m_raw;
            'h08: return m_mask;
            'h0C: return m_raw & m_mask;
            'h14: return m_prio;
            default: return 0;
        endcase
    endfunction

    function automatic void model_step(bit wr, bit rd, int a, int wd, bit trg, int smp);
        int clr = 0;
        // pop first
        if (rd && a >= 'h40 && a < 'hC0 && (((a - 'h40) & 'h1F) == 'h8)) begin
            int s = (a - 'h40) >> 5;
            if (!m_empty[s]) begin
                m_tail[s] = (m_tail[s] + 1) % 16;
                m_full[s] = 0;
                m_empty[s] = (m_tail[s] == m_head[s]);
            end
        end
        if (wr) begin
            if (a >= 'h40 && a < 'hC0) begin
                int s = (a - 'h40) >> 5;
                if (((a - 'h40) & 'h1F) == 'h0) m_mux[s] = wd & 'h33333333;
                if (((a - 'h40) & 'h1F) == 'h4) m_ctl[s] = wd;
            end
            if (a == 'h00) m_enable = wd & 'hF;
            if (a == 'h08) m_mask = wd & 'hF;
            if (a == 'h10) clr = wd & 'hF;
            if (a == 'h14) m_prio = wd & 'hFFFF;
        end
        m_raw = m_raw & ~clr;
        // then push
        if (trg && (m_enable & 1)) begin
            m_raw = m_raw | 1;
            if (!m_full[0]) begin
                m_mem[0][m_head[0]] = smp;
                m_head[0] = (m_head[0] + 1) % 16;
                m_empty[0] = 0;
                m_full[0] = (m_head[0] == m_tail[0]);
            end
        end
    endfunction

    // One clock: drive, compare away from the edge, advance the model.
    task automatic step(bit wr, bit rd, int a, int wd, bit trg, int smp, string tag);
        bus_wr = wr; bus_rd = rd; bus_addr = 8'(a); bus_wdata = 32'(wd);
        trig = trg; sample_in = 10'(smp);
        #1;
        checks++;
        if (irq !== ((m_raw & m_mask) != 0)) begin
            errors++;
            $display("FAIL %s irq got %b exp %b", tag, irq, (m_raw & m_mask) != 0);
        end
        if (rd) begin
            checks++;
            if (bus_rdata !== 32'(expect_read(a))) begin
                errors++;
                $display("FAIL %s addr %h rdata got %h exp %h", tag, a, bus_rdata, expect_read(a));
            end
        end
        @(posedge clk);
        model_step(wr, rd, a, wd, trg, smp);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; trig = 0;
    endtask

    task automatic rd(int a, string tag);  step(0, 1, a, 0, 0, 0, tag); endtask
    task automatic wr(int a, int d, string tag); step(1, 0, a, d, 0, 0, tag); endtask
    task automatic fire(int smp, string tag); step(0, 0, 'h3C, 0, 1, smp, tag); endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 'h18; a += 4) rd(a, "R1");
        for (int s = 0; s < 4; s++) rd('h4C + 'h20 * s, "R1 R2");
        // R8 trigger ignored while disabled; enable keeps 4 bits
        fire('h155, "R8");
        rd('h4C, "R8");
        rd('h04, "R8");
        wr('h00, 'hFE, "R8");
        rd('h00, "R8");
        fire('h0AA, "R8");
        rd('h4C, "R8");
        // R11 windows, R12 priority
        wr('h80, 'hFFFF_FFFF, "R11");
        rd('h80, "R11");
        wr('hA4, 'hDEAD_BEEF, "R11");
        rd('hA4, "R11");
        rd('h44, "R11");
        rd('h3C, "R11");
        rd('hB0, "R11");
        wr('h14, 'h1234_5678, "R12");
        rd('h14, "R12");
        rd('h14, "R12");
        // R3 R5 R10 basic push/pop
        wr('h00, 1, "R8");
        wr('h08, 1, "R10");
        for (int i = 0; i < 3; i++) fire('h200 + i, "R3");
        rd('h4C, "R2 R3");
        rd('h0C, "R10");
        for (int i = 0; i < 3; i++) rd('h48, "R5");
        rd('h4C, "R5");
        // R6 empty read
        rd('h48, "R6");
        rd('h48, "R6");
        rd('h4C, "R6");
        rd('h68, "R6");
        rd('h6C, "R6");
        // R9 clear, R10 mask
        wr('h10, 1, "R9");
        rd('h04, "R9");
        fire('h111, "R9");
        wr('h08, 0, "R10");
        rd('h0C, "R10");
        wr('h08, 'hF, "R10");
        step(1, 0, 'h10, 1, 1, 'h112, "R9 set wins");
        rd('h04, "R9");
        // R3 R4 fill to full, drop extra
        for (int i = 0; i < 16; i++) fire('h300 + 7 * i, "R3");
        rd('h4C, "R3 full");
        fire('h3FF, "R4");
        rd('h4C, "R4");
        // R7 pop and push while full
        step(0, 1, 'h48, 0, 1, 'h2AB, "R7 full");
        rd('h4C, "R7");
        for (int i = 0; i < 16; i++) rd('h48, "R5 R7");
        rd('h4C, "R5");
        // R7 pop and push while empty
        step(0, 1, 'h48, 0, 1, 'h0F0, "R7 empty");
        rd('h4C, "R7");
        rd('h48, "R7");
        rd('h4C, "R7");
        // R7 both mid-level
        fire('h011, "R7");
        fire('h022, "R7");
        step(0, 1, 'h48, 0, 1, 'h033, "R7 mid");
        rd('h4C, "R7");
        for (int i = 0; i < 3; i++) rd('h48, "R7");
        wr('h10, 'hF, "R9");
        rd('h04, "R9");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule